// File: doc/BRIEF.md
# Cubic B-Spline Fine Interpolator

This block refines a stream of coarse path points for one coordinate axis into closely spaced position set-points that lie on a uniform cubic B-spline. Coarse points arrive over a valid/ready input and are held in a four-entry sliding window. For every window the block emits `2^SUB_LOG2` samples, with the curve parameter u = i / 2^SUB_LOG2 for i = 0, 1, ..., 2^SUB_LOG2 - 1. The samples leave over a valid/ready output and serve as targets for a downstream position loop. Axes are independent, so a multi-axis path uses one instance per axis.

Each sample is the blend `[(1-u)^3*A + (3u^3-6u^2+4)*B + (-3u^3+3u^2+3u+1)*C + u^3*D] / 6` of the window points A (oldest) to D (newest). The block evaluates this in exact signed integer arithmetic with weights scaled by 2^(3*SUB_LOG2). It then rounds to the nearest integer, with exact halves rounded toward positive infinity.

When the last sample of a window has been produced, the oldest point is dropped. The next sample waits until a new point has been taken in.

Top module: `bspline_interp`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: No output is presented until four control points have been accepted.
- R3: Sample i of a window (A,B,C,D) equals floor(S / (6*M^3) + 1/2), where M = 2^SUB_LOG2 and S = (M-i)^3*A + (3i^3 - 6i^2*M + 4M^3)*B + (-3i^3 + 3i^2*M + 3i*M^2 + M^3)*C + i^3*D. All values are two's-complement `DATA_W`-bit integers.
- R4: Each window yields exactly M samples in order of rising i. A stream of K >= 4 points therefore yields M*(K-3) samples.
- R5: After the last sample of a window, the window advances by one point. No further sample appears until that point is accepted, and `in_ready_o` is 1 while the block waits for it.
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, the output stays valid and `out_data_o` does not change.
- R7: While four points are held, `in_ready_o` is 0 and an offered point is not taken.
- R8: A window of four equal points yields that same value for every i.
- R9: Every sample lies between the smallest and largest point of its window, including at full-scale positive and negative inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Control point offered |
| in_ready_o | output | 1 | Window has room for a point |
| in_data_i | input | DATA_W | Control point, signed |
| out_valid_o | output | 1 | Set-point available |
| out_ready_i | input | 1 | Consumer takes the set-point |
| out_data_o | output | DATA_W | Interpolated set-point, signed |

## Verification
The blend is tested against an integer model on several kinds of input. Equal points show that the four weights sum exactly to the scale factor. A small pattern places u = 0 samples exactly on +0.5 and -0.5, which separates round-half-up from truncation and from symmetric rounding. Points alternating between full-scale maximum and minimum expose accumulator overflow and errors in the sign handling of the division by three. Long random streams with random gaps on both handshakes show whether window advance, stalling and backpressure lose, duplicate or reorder samples.

// File: rtl/bspline_pkg.sv
package bspline_pkg;
  localparam int TAPS = 4;

  // weights reach 4*M^3 with M = 2^sub_log2
  function automatic int weight_w(int sub_log2);
    return 3 * sub_log2 + 3;
  endfunction

  // signed product, sum of four terms, rounding offset
  function automatic int acc_w(int data_w, int sub_log2);
    return data_w + weight_w(sub_log2) + 3;
  endfunction
endpackage

// File: rtl/bsp_window.sv
module bsp_window #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        shift_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic [TAPS-1:0][DATA_W-1:0] taps_o
);
  logic [TAPS-1:0][DATA_W-1:0] tap_q;

  // tap 0 holds the oldest point
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [DATA_W-1:0] nxt;
    if (k == TAPS - 1) begin : g_head
      assign nxt = data_i;
    end else begin : g_body
      assign nxt = tap_q[k+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tap_q[k] <= '0;
      else if (shift_i) tap_q[k] <= nxt;
    end
  end

  assign taps_o = tap_q;
endmodule

// File: rtl/bsp_basis.sv
module bsp_basis #(
  parameter int SUB_LOG2 = 3,
  parameter int W_W      = 12
) (
  input  logic [SUB_LOG2-1:0]    idx_i,
  output logic [3:0][W_W-1:0]    wgt_o
);
  localparam logic [W_W-1:0] STEPS  = W_W'(1) << SUB_LOG2;
  localparam logic [W_W-1:0] STEPS3 = W_W'(1) << (3 * SUB_LOG2);
  localparam logic [W_W-1:0] K3     = W_W'(3);
  localparam logic [W_W-1:0] K4     = W_W'(4);
  localparam logic [W_W-1:0] K6     = W_W'(6);

  logic [W_W-1:0] u1, u2, u3, v1;

  // modular intermediates; every final weight fits W_W bits
  always_comb begin
    u1       = W_W'(idx_i);
    u2       = u1 * u1;
    u3       = u2 * u1;
    v1       = STEPS - u1;
    wgt_o[0] = v1 * v1 * v1;
    wgt_o[1] = K3 * u3 + K4 * STEPS3 - K6 * STEPS * u2;
    wgt_o[2] = STEPS3 + K3 * (STEPS * (STEPS * u1 + u2) - u3);
    wgt_o[3] = u3;
  end
endmodule

// File: rtl/bsp_mac.sv
module bsp_mac #(
  parameter int DATA_W   = 16,
  parameter int SUB_LOG2 = 3,
  parameter int W_W      = 12,
  parameter int ACC_W    = 31
) (
  input  logic [3:0][DATA_W-1:0] pt_i,
  input  logic [3:0][W_W-1:0]    wgt_i,
  output logic [DATA_W-1:0]      pos_o
);
  localparam int SH = 3 * SUB_LOG2 + 1;
  localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(3) << (3 * SUB_LOG2);
  localparam logic signed [ACC_W-1:0] THREE = ACC_W'(3);

  logic signed [ACC_W-1:0] prod [4];
  logic signed [ACC_W-1:0] acc, shf, rem;

  for (genvar k = 0; k < 4; k++) begin : g_term
    assign prod[k] = ACC_W'(signed'(pt_i[k])) * signed'(ACC_W'(wgt_i[k]));
  end

  // floor((S + 3M^3) / (6M^3)) = floor(floor(.../2M^3) / 3)
  always_comb begin
    acc = prod[0] + prod[1] + prod[2] + prod[3] + HALF;
    shf = acc >>> SH;
    rem = shf % THREE;
    pos_o = DATA_W'(shf / THREE);
    if (shf[ACC_W-1] && rem != '0) pos_o = pos_o - DATA_W'(1);
  end
endmodule

// File: rtl/bspline_interp.sv
module bspline_interp
  import bspline_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SUB_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int W_W   = weight_w(SUB_LOG2);
  localparam int ACC_W = acc_w(DATA_W, SUB_LOG2);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TAPS);

  logic [CNT_W-1:0]            fill_q;
  logic [SUB_LOG2-1:0]         idx_q;
  logic [TAPS-1:0][DATA_W-1:0] win;
  logic [3:0][W_W-1:0]         wgt;
  logic [DATA_W-1:0]           pos;
  logic                        push, emit, last_sub;

  assign in_ready_o = (fill_q != FULL);
  assign push       = in_valid_i && in_ready_o;
  assign emit       = (fill_q == FULL) && (!out_valid_o || out_ready_i);
  assign last_sub   = &idx_q;

  bsp_window #(.DATA_W(DATA_W), .TAPS(TAPS)) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(push),
    .data_i (in_data_i),
    .taps_o (win)
  );

  bsp_basis #(.SUB_LOG2(SUB_LOG2), .W_W(W_W)) u_basis (
    .idx_i(idx_q),
    .wgt_o(wgt)
  );

  bsp_mac #(.DATA_W(DATA_W), .SUB_LOG2(SUB_LOG2), .W_W(W_W), .ACC_W(ACC_W)) u_mac (
    .pt_i (win),
    .wgt_i(wgt),
    .pos_o(pos)
  );

  // push needs room, emit needs a full window: never both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      idx_q  <= '0;
    end else begin
      if (emit) begin
        idx_q <= idx_q + 1'b1;
        if (last_sub) fill_q <= fill_q - 1'b1;
      end else if (push) begin
        fill_q <= fill_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (emit) begin
      out_valid_o <= 1'b1;
      out_data_o  <= pos;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bspline_interp_chk.sv
module bspline_interp_chk #(
  parameter int DATA_W   = 16,
  parameter int SUB_LOG2 = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o
);
  logic [31:0]         pts_cnt, seg_cnt;
  logic [SUB_LOG2-1:0] sub_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pts_cnt <= '0;
      seg_cnt <= '0;
      sub_cnt <= '0;
    end else begin
      if (in_valid_i && in_ready_o) pts_cnt <= pts_cnt + 1;
      if (out_valid_o && out_ready_i) begin
        sub_cnt <= sub_cnt + 1'b1;
        if (&sub_cnt) seg_cnt <= seg_cnt + 1;
      end
    end
  end

  // R2
  no_early_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> pts_cnt >= 32'd4);

  // R5
  window_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> pts_cnt >= seg_cnt + 32'd4);

  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R7
  window_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pts_cnt <= seg_cnt + 32'd5);
endmodule

bind bspline_interp bspline_interp_chk #(.DATA_W(DATA_W), .SUB_LOG2(SUB_LOG2)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o)
);

// File: tb/bspline_interp_bench.sv
module bspline_interp_bench;
  localparam int DATA_W   = 16;
  localparam int SUB_LOG2 = 3;
  localparam int STEPS    = 1 << SUB_LOG2;
  localparam int PMAX     = (1 << (DATA_W - 1)) - 1;
  localparam int PMIN     = -(1 << (DATA_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic signed [DATA_W-1:0] out_data;

  always #10 clk = ~clk;

  bspline_interp #(.DATA_W(DATA_W), .SUB_LOG2(SUB_LOG2)) u_bspline_interp (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  int total = 0, bad = 0;
  int feed[$];
  int pts[$];
  int fed = 0, got = 0;
  int vprob = 100, rprob = 100;
  bit took = 0, hold_prev = 0;
  int prev_od = 0;
  string tag = "R3";

  function automatic longint floor_div(longint n, longint d);
    longint q = n / d;
    if ((n % d) != 0 && n < 0) q = q - 1;
    return q;
  endfunction

  function automatic int ref_pos(int a, int b, int c, int d, int i);
    longint m = STEPS, k = i, s;
    s = (m - k) ** 3 * a
      + (3 * k ** 3 - 6 * k ** 2 * m + 4 * m ** 3) * b
      + (-3 * k ** 3 + 3 * k ** 2 * m + 3 * k * m ** 2 + m ** 3) * c
      + k ** 3 * d;
    return int'(floor_div(2 * s + 6 * m ** 3, 12 * m ** 3));
  endfunction

  function automatic int rnd_pt();
    logic signed [DATA_W-1:0] t = DATA_W'($urandom);
    return int'(t);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    feed.delete(); pts.delete(); fed = 0; got = 0; took = 0; hold_prev = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle: sample outputs at negedge, then drive for the next edge
  task automatic step();
    @(negedge clk);
    if (hold_prev) chk(out_valid && int'(out_data) == prev_od, "R6", int'(out_data), prev_od);
    if (took) begin in_valid = 1'b0; took = 0; end
    if (!in_valid && fed < feed.size() && $urandom_range(99) < vprob) begin
      in_valid = 1'b1;
      in_data  = DATA_W'(feed[fed]);
    end
    out_ready = ($urandom_range(99) < rprob);
    if (in_valid && in_ready) begin
      pts.push_back(feed[fed]);
      fed++;
      took = 1;
    end
    if (out_valid && out_ready) begin
      int seg = got >> SUB_LOG2;
      int i = got & (STEPS - 1);
      if (pts.size() < seg + 4) chk(0, "R5", pts.size(), seg + 4);
      else begin
        int e = ref_pos(pts[seg], pts[seg+1], pts[seg+2], pts[seg+3], i);
        int lo = pts[seg], hi = pts[seg];
        for (int j = 1; j < 4; j++) begin
          if (pts[seg+j] < lo) lo = pts[seg+j];
          if (pts[seg+j] > hi) hi = pts[seg+j];
        end
        chk(int'(out_data) == e, tag, int'(out_data), e);
        chk(int'(out_data) >= lo && int'(out_data) <= hi, "R9", int'(out_data), lo);
      end
      got++;
    end
    hold_prev = out_valid && !out_ready;
    prev_od = int'(out_data);
  endtask

  task automatic drain();
    int guard = 0;
    while ((fed < feed.size() || got < STEPS * (pts.size() - 3) || in_valid) && guard < 20000) begin
      step();
      guard++;
    end
    chk(got == STEPS * (pts.size() - 3), "R4", got, STEPS * (pts.size() - 3));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R4 watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);

    // R2: three points leave the output idle
    begin
      bit seen = 0;
      feed = '{100, -250, 900};
      repeat (15) begin step(); if (out_valid) seen = 1; end
      chk(!seen, "R2", seen, 0);
    end

    // fourth point: one full window, then the block waits (R5)
    feed.push_back(-40);
    while (got < STEPS) step();
    begin
      bit seen = 0;
      repeat (10) begin step(); if (out_valid) seen = 1; end
      chk(!seen, "R5", seen, 0);
      chk(in_ready == 1'b1, "R5", in_ready, 1);
    end

    // R7 with backpressure (R6 checked every held cycle)
    rprob = 0;
    feed.push_back(3000);
    feed.push_back(-7000);
    repeat (8) step();
    chk(fed == 5, "R7", fed, 5);
    chk(in_ready == 1'b0, "R7", in_ready, 0);
    rprob = 100;
    drain();

    // R8: equal points
    do_reset();
    tag = "R8";
    feed = '{-20000, -20000, -20000, -20000, -20000, -20000};
    drain();

    // R3 rounding ties at +0.5 and -0.5
    do_reset();
    tag = "R3";
    feed = '{0, 0, 3, 0, 0, -3, 0, 0};
    drain();

    // R9: full-scale extremes
    do_reset();
    tag = "R9";
    feed = '{PMAX, PMIN, PMAX, PMIN, PMIN, PMAX, PMAX, PMIN, PMAX, PMAX, PMIN, PMIN};
    drain();

    // random stream with random gaps on both sides
    do_reset();
    tag = "R3";
    vprob = 60; rprob = 60;
    for (int n = 0; n < 300; n++) feed.push_back(rnd_pt());
    drain();

    summary();
  end
endmodule